// File: doc/BRIEF.md
# Page Write Buffer Controller

This block sits between a serial command engine and a nonvolatile memory array. When the engine decodes a write command it hands over the start address. It then passes each received data byte with a one-cycle strobe. When chip select rises it sends one event, with a flag saying whether the rise came exactly on a byte boundary. The block gathers the bytes into a page-sized buffer, indexed by the low address bits. When a burst runs past the end of the page, the index wraps to the start of that same page, and later bytes replace earlier ones.

A burst is committed only when four conditions hold: the write enable latch was set when the command began, the target block is not protected, the chip-select rise was byte aligned, and at least one byte arrived. The block then runs a timed internal write cycle with its busy flag raised. During that cycle it streams the received bytes to the array write port, one per clock. Page locations that were not received are never touched. At the end of the cycle it emits a pulse that clears the write enable latch. While busy it ignores every command input, so the engine may only serve status reads.

Top module: `pwb_ctrl`

## Requirements
- R1: After reset, `wip`, `arr_we` and `wel_clr` are all 0.
- R2: Data byte k (k = 0, 1, ...) of a committed burst that started at address A is written to the address with the upper bits of A and the low log2(PAGE_BYTES) bits equal to (A + k) mod PAGE_BYTES. If a burst is longer than a page, the byte received last for a location is the one written.
- R3: A committed burst writes every received location exactly once and writes no other address. The number of `arr_we` strobes equals min(bytes received, PAGE_BYTES).
- R4: A cycle starts only on a `cs_rise` with `cs_on_byte` = 1 after at least one byte. A rise with `cs_on_byte` = 0, or a rise with no data byte, writes nothing and leaves `wip` at 0.
- R5: If `wel` is 0 when `cmd_start` is accepted, the burst writes nothing and `wip` stays 0.
- R6: `bp_level` is sampled at `cmd_start` and decoded against the two top address bits T. Value 0 protects nothing; 1 protects T = 3; 2 protects T = 2 or 3; 3 protects the whole array. A burst whose start address is protected writes nothing and leaves `wip` at 0.
- R7: `wip` rises in the cycle after the accepted `cs_rise` is sampled and stays high for exactly max(WC_CYCLES, PAGE_BYTES+3) cycles.
- R8: `wel_clr` is a single-cycle pulse in the first cycle after `wip` falls. It occurs once per completed write cycle and at no other time.
- R9: `arr_we` is asserted only while `wip` is 1.
- R10: While `wip` is 1, `cmd_start`, `byte_vld` and `cs_rise` are ignored. A complete write command issued then causes no array write and no second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Write command decoded; latch start address and permission |
| cmd_addr | input | ADDR_W | Start byte address of the write command |
| byte_vld | input | 1 | One complete data byte received |
| byte_data | input | DATA_W | The received data byte |
| cs_rise | input | 1 | Chip select has gone inactive |
| cs_on_byte | input | 1 | With `cs_rise`: the rise followed the last bit of a data byte |
| wel | input | 1 | Current write enable latch |
| bp_level | input | 2 | Block protection level |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| wip | output | 1 | Internal write cycle in progress |
| wel_clr | output | 1 | Pulse: clear the write enable latch |

## Verification
The bench builds the block with a 64-byte array, an 8-byte page and a 20-cycle write time. This gives eight pages and two pages per protection quarter. With that size, every start offset and every page can be swept with burst lengths of one byte, a full page, and more than a page. Those sweeps reach both in-page wrap and overwrite. The bench also sweeps all protection levels against every quarter, and each rejection condition. A full model of the small array is compared after every burst, so stray writes anywhere are caught.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PROG = 2'd2
  } pwb_state_e;

  // Decode of the block protection level against the two top address bits.
  function automatic logic blk_locked(input logic [1:0] lvl, input logic [1:0] top);
    case (lvl)
      2'b00:   return 1'b0;
      2'b01:   return (top == 2'b11);
      2'b10:   return top[1];
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_hit,
  output logic                     any_valid
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vmask;

  // Simple dual-port storage with registered read, block RAM friendly.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= mem[rd_idx];
  end

  // One valid flag per slot, marking bytes received in this burst.
  always_ff @(posedge clk) begin
    if (rst) begin
      vmask  <= '0;
      rd_hit <= 1'b0;
    end else begin
      if (clr)        vmask         <= '0;
      else if (wr_en) vmask[wr_idx] <= 1'b1;
      rd_hit <= rd_en & vmask[rd_idx];
    end
  end

  assign any_valid = |vmask;

endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done,
  output logic last
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  assign last = busy && (cnt == CNT_W'(CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= '0;
        end
      end else if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  parameter int WC_CYCLES  = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              cs_rise,
  input  logic              cs_on_byte,
  input  logic              wel,
  input  logic [1:0]        bp_level,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              wip,
  output logic              wel_clr
);

  localparam int PTR_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - PTR_W;
  // The cycle must cover the full page scan plus its pipeline.
  localparam int CYC    = (WC_CYCLES > PAGE_BYTES + 3) ? WC_CYCLES : PAGE_BYTES + 3;

  pwb_state_e        state;
  logic [PAGE_W-1:0] page_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              ok_q;
  logic              scan_on;
  logic [PTR_W-1:0]  scan_idx;
  logic [PTR_W-1:0]  rd_idx_q;

  logic              fill_we;
  logic              buf_clr;
  logic              prog_go;
  logic              t_busy;
  logic              t_done;
  logic              t_last;
  logic [DATA_W-1:0] rd_data;
  logic              rd_hit;
  logic              any_valid;

  assign fill_we = (state == ST_FILL) && byte_vld;
  assign buf_clr = (state == ST_IDLE) && cmd_start;
  assign prog_go = (state == ST_FILL) && cs_rise && cs_on_byte && ok_q && any_valid;

  // Command sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      page_q <= '0;
      ptr_q  <= '0;
      ok_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmd_start) begin
            state  <= ST_FILL;
            page_q <= cmd_addr[ADDR_W-1:PTR_W];
            ptr_q  <= cmd_addr[PTR_W-1:0];
            ok_q   <= wel && !blk_locked(bp_level, cmd_addr[ADDR_W-1 -: 2]);
          end
        end
        ST_FILL: begin
          if (byte_vld) ptr_q <= ptr_q + 1'b1;
          if (cs_rise)  state <= prog_go ? ST_PROG : ST_IDLE;
        end
        ST_PROG: begin
          if (t_last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Page scan during the write cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      scan_on  <= 1'b0;
      scan_idx <= '0;
      rd_idx_q <= '0;
    end else begin
      if (prog_go) begin
        scan_on  <= 1'b1;
        scan_idx <= '0;
      end else if (scan_on) begin
        scan_idx <= scan_idx + 1'b1;
        if (scan_idx == PTR_W'(PAGE_BYTES - 1)) scan_on <= 1'b0;
      end
      if (scan_on) rd_idx_q <= scan_idx;
    end
  end

  pwb_page_buf #(
    .DEPTH  (PAGE_BYTES),
    .DATA_W (DATA_W)
  ) u_buf (
    .clk       (clk),
    .rst       (rst),
    .clr       (buf_clr),
    .wr_en     (fill_we),
    .wr_idx    (ptr_q),
    .wr_data   (byte_data),
    .rd_en     (scan_on),
    .rd_idx    (scan_idx),
    .rd_data   (rd_data),
    .rd_hit    (rd_hit),
    .any_valid (any_valid)
  );

  pwb_cycle_timer #(
    .CYCLES (CYC)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (prog_go),
    .busy  (t_busy),
    .done  (t_done),
    .last  (t_last)
  );

  // Registered array port
  always_ff @(posedge clk) begin
    if (rst) begin
      arr_we    <= 1'b0;
      arr_addr  <= '0;
      arr_wdata <= '0;
    end else begin
      arr_we    <= rd_hit;
      arr_addr  <= {page_q, rd_idx_q};
      arr_wdata <= rd_data;
    end
  end

  assign wip     = t_busy;
  assign wel_clr = t_done;

endmodule

// File: rtl/pwb_ctrl_chk.sv
module pwb_ctrl_chk #(
  parameter int WC_CYCLES  = 5000,
  parameter int PAGE_BYTES = 32
) (
  input logic clk,
  input logic rst,
  input logic cs_rise,
  input logic cs_on_byte,
  input logic arr_we,
  input logic wip,
  input logic wel_clr
);

  localparam int CYC = (WC_CYCLES > PAGE_BYTES + 3) ? WC_CYCLES : PAGE_BYTES + 3;

  int run_len;

  always_ff @(posedge clk) begin
    if (rst || !wip) run_len <= 0;
    else             run_len <= run_len + 1;
  end

  AST_WE_INSIDE_CYCLE: assert property (@(posedge clk) disable iff (rst) arr_we |-> wip); // R9
  AST_START_ON_BYTE: assert property (@(posedge clk) disable iff (rst) $rose(wip) |-> $past(cs_rise && cs_on_byte)); // R4
  AST_CLR_AT_END: assert property (@(posedge clk) disable iff (rst) wel_clr |-> $fell(wip)); // R8
  AST_END_GIVES_CLR: assert property (@(posedge clk) disable iff (rst) $fell(wip) |-> wel_clr); // R8
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst) wel_clr |=> !wel_clr); // R8
  AST_CYCLE_LENGTH: assert property (@(posedge clk) disable iff (rst) $fell(wip) |-> (run_len == CYC)); // R7

endmodule

bind pwb_ctrl pwb_ctrl_chk #(
  .WC_CYCLES  (WC_CYCLES),
  .PAGE_BYTES (PAGE_BYTES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_rise    (cs_rise),
  .cs_on_byte (cs_on_byte),
  .arr_we     (arr_we),
  .wip        (wip),
  .wel_clr    (wel_clr)
);

// File: tb/pwb_ctrl_tb.sv
`timescale 1ns/1ps
module pwb_ctrl_tb;

  localparam int AW    = 6;
  localparam int DW    = 8;
  localparam int PB    = 8;
  localparam int WC    = 20;
  localparam int NLOC  = 1 << AW;
  localparam int EXP_C = (WC > PB + 3) ? WC : PB + 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_start = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic          byte_vld = 1'b0;
  logic [DW-1:0] byte_data = '0;
  logic          cs_rise = 1'b0;
  logic          cs_on_byte = 1'b0;
  logic          wel = 1'b0;
  logic [1:0]    bp_level = 2'b00;
  logic          arr_we;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;
  logic          wip;
  logic          wel_clr;

  always #10 clk = ~clk;

  pwb_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .WC_CYCLES(WC)
  ) u_dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
    .cs_on_byte(cs_on_byte), .wel(wel), .bp_level(bp_level),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .wip(wip), .wel_clr(wel_clr)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int txn_no  = 0;

  logic [DW-1:0] dut_mem [NLOC];
  logic [DW-1:0] exp_mem [NLOC];

  int   win_wip, win_we, win_clr, win_bad_clr, win_bad_we;
  logic prev_wip = 1'b0;

  // Output monitor: sampled on the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (wip) win_wip = win_wip + 1;
      if (arr_we) begin
        dut_mem[arr_addr] = arr_wdata;
        win_we = win_we + 1;
        if (!wip) win_bad_we = win_bad_we + 1;
      end
      if (wel_clr) begin
        win_clr = win_clr + 1;
        if (!(prev_wip && !wip)) win_bad_clr = win_bad_clr + 1;
      end
      prev_wip = wip;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (txn %0d)", what, act, exp, txn_no);
    end
  endtask

  function automatic bit locked(input int lvl, input int addr);
    int q;
    q = addr / (NLOC / 4);
    if (lvl == 0) return 1'b0;
    if (lvl == 1) return q == 3;
    if (lvl == 2) return q >= 2;
    return 1'b1;
  endfunction

  task automatic send_cmd(input int start, input int n, input bit bnd, input bit wen, input int lvl);
    @(negedge clk);
    cmd_start = 1'b1; cmd_addr = AW'(start); wel = wen; bp_level = 2'(lvl);
    @(negedge clk);
    cmd_start = 1'b0;
    for (int k = 0; k < n; k++) begin
      byte_vld  = 1'b1;
      byte_data = DW'(start * 5 + k * 29 + txn_no * 3 + 1);
      @(negedge clk);
      byte_vld = 1'b0;
      if (k % 3 == 2) @(negedge clk);
    end
    cs_rise = 1'b1; cs_on_byte = bnd;
    @(negedge clk);
    cs_rise = 1'b0; cs_on_byte = 1'b0;
  endtask

  // One burst with its expected effect and checks; intrude adds a second
  // command while the write cycle runs (R10).
  task automatic run_txn(input int start, input int n, input bit bnd, input bit wen,
                         input int lvl, input bit intrude, input string tag);
    bit acc;
    int mism;
    int exp_we;
    txn_no++;
    win_wip = 0; win_we = 0; win_clr = 0; win_bad_clr = 0; win_bad_we = 0;
    acc = wen && !locked(lvl, start) && bnd && (n > 0);
    if (acc) begin
      for (int k = 0; k < n; k++)
        exp_mem[(start / PB) * PB + ((start % PB + k) % PB)] =
          DW'(start * 5 + k * 29 + txn_no * 3 + 1);
    end
    exp_we = acc ? ((n < PB) ? n : PB) : 0;
    send_cmd(start, n, bnd, wen, lvl);
    if (intrude) begin
      @(negedge clk);
      send_cmd(start ^ 32, 4, 1'b1, 1'b1, 0);
    end
    repeat (EXP_C + 8) @(negedge clk);
    mism = 0;
    for (int i = 0; i < NLOC; i++) if (dut_mem[i] !== exp_mem[i]) mism++;
    check(mism == 0, {tag, " R2 R3 array contents mismatches"}, mism, 0);
    check(win_we == exp_we, {tag, " R3 write strobe count"}, win_we, exp_we);
    check(win_wip == (acc ? EXP_C : 0), {tag, " R7 wip cycles"}, win_wip, acc ? EXP_C : 0);
    check(win_clr == (acc ? 1 : 0) && win_bad_clr == 0, {tag, " R8 wel_clr pulses"},
          win_clr, acc ? 1 : 0);
    check(win_bad_we == 0, {tag, " R9 write outside cycle"}, win_bad_we, 0);
  endtask

  initial begin
    for (int i = 0; i < NLOC; i++) begin
      dut_mem[i] = DW'(i) ^ 8'hA5;
      exp_mem[i] = DW'(i) ^ 8'hA5;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(wip == 1'b0, "R1 wip after reset", int'(wip), 0);
    check(arr_we == 1'b0, "R1 arr_we after reset", int'(arr_we), 0);
    check(wel_clr == 1'b0, "R1 wel_clr after reset", int'(wel_clr), 0);

    // R2 R3 R7 R8: every start address, lengths below, at and beyond a page
    for (int a = 0; a < NLOC; a++) begin
      run_txn(a, 1, 1'b1, 1'b1, 0, 1'b0, "R2");
      run_txn(a, 3, 1'b1, 1'b1, 0, 1'b0, "R2");
      run_txn(a, PB, 1'b1, 1'b1, 0, 1'b0, "R2 full page");
      run_txn(a, PB + 1, 1'b1, 1'b1, 0, 1'b0, "R2 wrap");
      run_txn(a, PB + 4, 1'b1, 1'b1, 0, 1'b0, "R2 overwrite");
    end

    // R4: misaligned chip-select rise and empty bursts
    for (int a = 0; a < NLOC; a += 5) begin
      run_txn(a, 2, 1'b0, 1'b1, 0, 1'b0, "R4 misaligned");
      run_txn(a, 0, 1'b1, 1'b1, 0, 1'b0, "R4 no data");
    end

    // R5: write enable latch clear
    for (int a = 0; a < NLOC; a += 7)
      run_txn(a, 4, 1'b1, 1'b0, 0, 1'b0, "R5 no wel");

    // R6: every protection level against every half-page start
    for (int l = 0; l < 4; l++)
      for (int a = 0; a < NLOC; a += 4)
        run_txn(a, 2, 1'b1, 1'b1, l, 1'b0, "R6 protect");

    // R10: a full command during the write cycle is ignored
    for (int a = 0; a < 32; a += 3)
      run_txn(a, 5, 1'b1, 1'b1, 0, 1'b1, "R10 busy");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule